// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two 16-bit ports, A and B, without inverting any bit. It holds one storage register for each direction of transfer. The data path is split into two 8-bit lanes. Each lane has its own set of controls: an isolate input, a direction input, a capture clock for each register, and a source select for each direction. A lane that is not isolated drives exactly one of its two ports. The select for that direction decides what the driven port shows: either the live data arriving on the opposite port, or the contents of the register that direction owns.

Loading the registers does not depend on the output controls. Every rising edge of a lane's capture clock stores that lane's port data, even while the lane is isolated or driving the other way. Each bidirectional port is modelled as three vectors: an input, an output, and a per-lane output enable. A surrounding pad ring or bus fabric combines them into the real bus.

Top module: `regd_xcvr`

## Requirements
- R1: An active-low `rst_n` clears both registers of every lane to zero. Stored mode right after reset therefore drives 8'h00.
- R2: While `iso[l]` is 1, lane l enables neither port. Bit l of both `a_oe` and `b_oe` is 0. Lane l covers data bits 8l+7 down to 8l.
- R3: While `iso[l]` is 0, lane l enables exactly one port. `dir[l]`=1 sets `b_oe[l]`. `dir[l]`=0 sets `a_oe[l]`.
- R4: On every lane whose enable bit for a port is 0, that port's output bits are 8'h00.
- R5: While lane l drives B with `sel_ab[l]`=0, the lane's B output equals its A input bit for bit, with no inversion.
- R6: While lane l drives B with `sel_ab[l]`=1, the B output shows the lane's A-side register. The output changes right after a rising edge of `clk_ab[l]`.
- R7: While lane l drives A with `sel_ba[l]`=0, the lane's A output equals its B input bit for bit.
- R8: While lane l drives A with `sel_ba[l]`=1, the A output shows the lane's B-side register. The output changes right after a rising edge of `clk_ba[l]`.
- R9: Each rising edge of `clk_ab[l]` loads lane l's A input into its A-side register, whatever the values of `iso`, `dir` and the selects.
- R10: Each rising edge of `clk_ba[l]` loads lane l's B input into its B-side register, whatever the values of `iso`, `dir` and the selects.
- R11: The controls, clocks and data of one lane have no effect on the outputs, enables or registers of the other lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low clear of all storage registers |
| clk_ab | input | 2 | Per-lane capture clock for the A-side register (rising edge) |
| clk_ba | input | 2 | Per-lane capture clock for the B-side register (rising edge) |
| iso | input | 2 | Per-lane isolate: 1 releases both ports |
| dir | input | 2 | Per-lane direction: 1 drives B, 0 drives A |
| sel_ab | input | 2 | Per-lane source for B: 0 live A data, 1 A-side register |
| sel_ba | input | 2 | Per-lane source for A: 0 live B data, 1 B-side register |
| a_in | input | 16 | Data arriving on port A |
| a_out | output | 16 | Data to drive onto port A |
| a_oe | output | 2 | Per-lane enable for port A |
| b_in | input | 16 | Data arriving on port B |
| b_out | output | 16 | Data to drive onto port B |
| b_oe | output | 2 | Per-lane enable for port B |

## Verification
The bound checker tests the combinational rules at every evaluation, separately for each lane: an isolated lane stays quiet, a lane that is not isolated enables exactly one side, the side matches the direction, output bits are zero wherever the enable is off, and a live path copies the opposite input unchanged. Some behaviour depends on history, and only the bench's scenarios can show it. This covers the register contents, captures made while a lane is isolated or facing the other way, the update that follows a capture edge in stored mode, and the reset value. The bench's behavioural model of the two registers per lane is compared against both lanes on every clock.

// File: rtl/regd_xcvr_pkg.sv
package regd_xcvr_pkg;

    // Control set belonging to one byte lane
    typedef struct packed {
        logic iso;
        logic dir;
        logic sel_ab;
        logic sel_ba;
    } lane_ctl_t;

    // Which port a lane currently drives
    typedef enum logic [1:0] {
        DRV_NONE = 2'd0,
        DRV_A    = 2'd1,
        DRV_B    = 2'd2
    } drive_e;

endpackage

// File: rtl/regd_xcvr_store.sv
module regd_xcvr_store #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);

    logic [W-1:0] q_d;
    logic [W-1:0] q_q;

    // Loading is unconditional: every rising edge captures
    always_comb begin
        q_d = d_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign q_out = q_q;

endmodule

// File: rtl/regd_xcvr_route.sv
module regd_xcvr_route
    import regd_xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  lane_ctl_t    ctl,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic [W-1:0] reg_a,
    input  logic [W-1:0] reg_b,
    output logic [W-1:0] a_out,
    output logic [W-1:0] b_out,
    output logic         a_oe,
    output logic         b_oe
);

    typedef struct packed {
        logic [W-1:0] a_out;
        logic [W-1:0] b_out;
        logic         a_oe;
        logic         b_oe;
    } route_t;

    drive_e drive;
    route_t route_d;

    always_comb begin
        if (ctl.iso) begin
            drive = DRV_NONE;
        end else if (ctl.dir) begin
            drive = DRV_B;
        end else begin
            drive = DRV_A;
        end
    end

    always_comb begin
        route_d = '0;
        unique case (drive)
            DRV_B: begin
                route_d.b_oe  = 1'b1;
                route_d.b_out = ctl.sel_ab ? reg_a : a_in;
            end
            DRV_A: begin
                route_d.a_oe  = 1'b1;
                route_d.a_out = ctl.sel_ba ? reg_b : b_in;
            end
            default: begin
                route_d = '0;
            end
        endcase
    end

    assign a_out = route_d.a_out;
    assign b_out = route_d.b_out;
    assign a_oe  = route_d.a_oe;
    assign b_oe  = route_d.b_oe;

endmodule

// File: rtl/regd_xcvr_lane.sv
module regd_xcvr_lane
    import regd_xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         rst_n,
    input  logic         clk_ab,
    input  logic         clk_ba,
    input  lane_ctl_t    ctl,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] b_out,
    output logic         a_oe,
    output logic         b_oe
);

    logic [W-1:0] reg_a;
    logic [W-1:0] reg_b;

    regd_xcvr_store #(.W(W)) u_store_a (
        .clk   (clk_ab),
        .rst_n (rst_n),
        .d_in  (a_in),
        .q_out (reg_a)
    );

    regd_xcvr_store #(.W(W)) u_store_b (
        .clk   (clk_ba),
        .rst_n (rst_n),
        .d_in  (b_in),
        .q_out (reg_b)
    );

    regd_xcvr_route #(.W(W)) u_route (
        .ctl   (ctl),
        .a_in  (a_in),
        .b_in  (b_in),
        .reg_a (reg_a),
        .reg_b (reg_b),
        .a_out (a_out),
        .b_out (b_out),
        .a_oe  (a_oe),
        .b_oe  (b_oe)
    );

endmodule

// File: rtl/regd_xcvr.sv
module regd_xcvr
    import regd_xcvr_pkg::*;
#(
    parameter  int LANES  = 2,
    parameter  int LANE_W = 8,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              rst_n,
    input  logic [LANES-1:0]  clk_ab,
    input  logic [LANES-1:0]  clk_ba,
    input  logic [LANES-1:0]  iso,
    input  logic [LANES-1:0]  dir,
    input  logic [LANES-1:0]  sel_ab,
    input  logic [LANES-1:0]  sel_ba,
    input  logic [DATA_W-1:0] a_in,
    output logic [DATA_W-1:0] a_out,
    output logic [LANES-1:0]  a_oe,
    input  logic [DATA_W-1:0] b_in,
    output logic [DATA_W-1:0] b_out,
    output logic [LANES-1:0]  b_oe
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        lane_ctl_t ctl;

        always_comb begin
            ctl.iso    = iso[l];
            ctl.dir    = dir[l];
            ctl.sel_ab = sel_ab[l];
            ctl.sel_ba = sel_ba[l];
        end

        regd_xcvr_lane #(.W(LANE_W)) u_lane (
            .rst_n  (rst_n),
            .clk_ab (clk_ab[l]),
            .clk_ba (clk_ba[l]),
            .ctl    (ctl),
            .a_in   (a_in[l*LANE_W +: LANE_W]),
            .b_in   (b_in[l*LANE_W +: LANE_W]),
            .a_out  (a_out[l*LANE_W +: LANE_W]),
            .b_out  (b_out[l*LANE_W +: LANE_W]),
            .a_oe   (a_oe[l]),
            .b_oe   (b_oe[l])
        );
    end

endmodule

// File: rtl/regd_xcvr_chk.sv
module regd_xcvr_chk #(
    parameter  int LANES  = 2,
    parameter  int LANE_W = 8,
    localparam int DATA_W = LANES * LANE_W
) (
    input logic              rst_n,
    input logic [LANES-1:0]  iso,
    input logic [LANES-1:0]  dir,
    input logic [LANES-1:0]  sel_ab,
    input logic [LANES-1:0]  sel_ba,
    input logic [DATA_W-1:0] a_in,
    input logic [DATA_W-1:0] a_out,
    input logic [LANES-1:0]  a_oe,
    input logic [DATA_W-1:0] b_in,
    input logic [DATA_W-1:0] b_out,
    input logic [LANES-1:0]  b_oe
);

    for (genvar l = 0; l < LANES; l++) begin : g_chk
        always_comb begin
            if (rst_n && iso[l]) begin
                assert_iso_quiet_R2: assert (!a_oe[l] && !b_oe[l])
                    else $error("lane %0d drives while isolated", l);
            end
            if (rst_n && !iso[l]) begin
                assert_one_side_R3: assert ($countones({a_oe[l], b_oe[l]}) == 1 && b_oe[l] == dir[l])
                    else $error("lane %0d enable mismatch", l);
            end
            if (rst_n && !a_oe[l]) begin
                assert_a_idle_zero_R4: assert (a_out[l*LANE_W +: LANE_W] == '0)
                    else $error("lane %0d A data while disabled", l);
            end
            if (rst_n && !b_oe[l]) begin
                assert_b_idle_zero_R4: assert (b_out[l*LANE_W +: LANE_W] == '0)
                    else $error("lane %0d B data while disabled", l);
            end
            if (rst_n && b_oe[l] && !sel_ab[l]) begin
                assert_live_ab_R5: assert (b_out[l*LANE_W +: LANE_W] == a_in[l*LANE_W +: LANE_W])
                    else $error("lane %0d live A to B mismatch", l);
            end
            if (rst_n && a_oe[l] && !sel_ba[l]) begin
                assert_live_ba_R7: assert (a_out[l*LANE_W +: LANE_W] == b_in[l*LANE_W +: LANE_W])
                    else $error("lane %0d live B to A mismatch", l);
            end
        end
    end

endmodule

bind regd_xcvr regd_xcvr_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
    .rst_n  (rst_n),
    .iso    (iso),
    .dir    (dir),
    .sel_ab (sel_ab),
    .sel_ba (sel_ba),
    .a_in   (a_in),
    .a_out  (a_out),
    .a_oe   (a_oe),
    .b_in   (b_in),
    .b_out  (b_out),
    .b_oe   (b_oe)
);

// File: tb/regd_xcvr_bench.sv
`timescale 1ns/1ps
module regd_xcvr_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  clk_ab, clk_ba, iso, dir, sel_ab, sel_ba;
    logic [15:0] a_in, b_in;
    logic [15:0] a_out, b_out;
    logic [1:0]  a_oe, b_oe;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    logic [7:0] m_a [2];
    logic [7:0] m_b [2];

    always #4 clk = ~clk;

    regd_xcvr u_regd_xcvr (
        .rst_n (rst_n), .clk_ab (clk_ab), .clk_ba (clk_ba),
        .iso (iso), .dir (dir), .sel_ab (sel_ab), .sel_ba (sel_ba),
        .a_in (a_in), .a_out (a_out), .a_oe (a_oe),
        .b_in (b_in), .b_out (b_out), .b_oe (b_oe)
    );

    task automatic check_lane(input string tag, input int l);
        logic       eoa, eob;
        logic [7:0] ea, eb;
        eoa = !iso[l] && !dir[l];
        eob = !iso[l] && dir[l];
        eb  = eob ? (sel_ab[l] ? m_a[l] : a_in[l*8 +: 8]) : 8'h00;
        ea  = eoa ? (sel_ba[l] ? m_b[l] : b_in[l*8 +: 8]) : 8'h00;
        checks++;
        if (a_oe[l] !== eoa || b_oe[l] !== eob ||
            a_out[l*8 +: 8] !== ea || b_out[l*8 +: 8] !== eb) begin
            errors++;
            $display("FAIL %s lane %0d: got a_oe=%b b_oe=%b a=%h b=%h, exp a_oe=%b b_oe=%b a=%h b=%h",
                     tag, l, a_oe[l], b_oe[l], a_out[l*8 +: 8], b_out[l*8 +: 8], eoa, eob, ea, eb);
        end
    endtask

    // Whole-model comparison of both lanes on every clock (R11)
    always @(negedge clk) begin
        if (rst_n) begin
            for (int l = 0; l < 2; l++) check_lane("R11", l);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles, exp at most 50000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic pulse_ab(input int l);
        @(posedge clk);
        clk_ab[l] = 1'b1;
        m_a[l] = a_in[l*8 +: 8];
        @(posedge clk);
        clk_ab[l] = 1'b0;
    endtask

    task automatic pulse_ba(input int l);
        @(posedge clk);
        clk_ba[l] = 1'b1;
        m_b[l] = b_in[l*8 +: 8];
        @(posedge clk);
        clk_ba[l] = 1'b0;
    endtask

    task automatic run_lane(input int l);
        int o;
        logic [7:0] pat [4];
        o = 1 - l;
        pat[0] = 8'h00; pat[1] = 8'hFF; pat[2] = 8'h81; pat[3] = 8'h6E;
        // other lane held live A to B with its own data
        @(posedge clk);
        iso[o] = 1'b0; dir[o] = 1'b1; sel_ab[o] = 1'b0;
        a_in[o*8 +: 8] = 8'h5A;
        // isolation with captures (R2, R4, R9, R10)
        iso[l] = 1'b1; dir[l] = 1'b1; sel_ab[l] = 1'b1; sel_ba[l] = 1'b1;
        a_in[l*8 +: 8] = 8'hA5 ^ 8'(l);
        b_in[l*8 +: 8] = 8'h3C ^ 8'(l);
        @(negedge clk); check_lane("R2", l); check_lane("R4", l);
        pulse_ab(l);
        pulse_ba(l);
        @(negedge clk); check_lane("R2", l); check_lane("R11", o);
        @(posedge clk); iso[l] = 1'b0;
        @(negedge clk); check_lane("R9", l);
        @(posedge clk); dir[l] = 1'b0;
        @(negedge clk); check_lane("R10", l); check_lane("R3", l);
        // live A to B (R3, R5)
        @(posedge clk); dir[l] = 1'b1; sel_ab[l] = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); a_in[l*8 +: 8] = pat[i];
            @(negedge clk); check_lane("R5", l); check_lane("R3", l);
        end
        // stored A to B updating after a capture (R6)
        @(posedge clk); sel_ab[l] = 1'b1; a_in[l*8 +: 8] = 8'hC3;
        @(negedge clk); check_lane("R6", l);
        pulse_ab(l);
        @(negedge clk); check_lane("R6", l);
        // live B to A (R7)
        @(posedge clk); dir[l] = 1'b0; sel_ba[l] = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); b_in[l*8 +: 8] = ~pat[i];
            @(negedge clk); check_lane("R7", l);
        end
        // stored B to A (R8)
        @(posedge clk); sel_ba[l] = 1'b1; b_in[l*8 +: 8] = 8'h99;
        @(negedge clk); check_lane("R8", l);
        pulse_ba(l);
        @(negedge clk); check_lane("R8", l);
        // capture while driving the other way does not disturb lane o (R11)
        pulse_ab(l);
        @(negedge clk); check_lane("R11", o); check_lane("R9", l);
    endtask

    initial begin
        rst_n = 1'b0;
        clk_ab = '0; clk_ba = '0; iso = 2'b11; dir = '0;
        sel_ab = '0; sel_ba = '0; a_in = '0; b_in = '0;
        for (int l = 0; l < 2; l++) begin
            m_a[l] = 8'h00;
            m_b[l] = 8'h00;
        end
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // reset value shows in stored mode (R1)
        @(posedge clk); iso = 2'b00; dir = 2'b11; sel_ab = 2'b11;
        a_in = 16'hFFFF; b_in = 16'hFFFF;
        @(negedge clk); check_lane("R1", 0); check_lane("R1", 1);
        @(posedge clk); dir = 2'b00; sel_ba = 2'b11;
        @(negedge clk); check_lane("R1", 0); check_lane("R1", 1);
        run_lane(0);
        run_lane(1);
        repeat (2) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule